// File: doc/BRIEF.md
# Linear CCD Readout Timing Generator

This block drives the control pins of a linear CCD image sensor from a fast system clock. It runs a master clock for the sensor all the time, with a 50% duty cycle. On request it issues the charge-transfer pulse pair: the integration-clear gate goes low, and the shift gate pulses high inside that low window. Once the pair is done, the block steps through one full frame of pixel slots. Each slot spans two master-clock periods. The frame consists of leading dummy slots, then image pixels, then trailing dummy slots.

The gate release is placed on a rising master-clock edge, and that edge also becomes the start of the first pixel slot. Every later sample strobe therefore falls at the start of a slot, and no sample straddles two pixels. Each strobe comes with a pixel index, which an external converter and store can use.

A clear request runs the same gate sequence with the strobes suppressed. The block then waits one frame time plus a pad, and this flushes stale charge out of the sensor. The falling edge of the shift gate produces a one-cycle pulse that marks the start of the next exposure. One parameter flips the polarity of all three sensor pins, for boards that drive them through an inverting buffer.

Top module: `ccd_timing_gen`

## Requirements
- R1: `mclk` runs continuously from reset, starting low. Each phase lasts exactly HALF_CYC system cycles, so one master period is 2*HALF_CYC cycles.
- R2: `sample_strobe` is a single-cycle pulse. It only ever appears in the first cycle of a master-clock high phase (the cycle in which `mclk` has just risen).
- R3: While idle, including during and after reset: `icg` is high, `sh` is low, and `sample_strobe`, `integ_start` and `done` are all low. `mclk` is low during reset.
- R4: After an accepted request, `icg` falls first. `sh` rises exactly ICG_LEAD_CYC cycles after `icg` falls and stays high for exactly SH_HIGH_CYC cycles. `icg` then stays low for at least SH_TAIL_CYC and at most SH_TAIL_CYC+2*HALF_CYC-1 cycles after `sh` falls.
- R5: `icg` rises in the same cycle that `mclk` rises. For a normal capture, the strobe for pixel 0 is high in that same cycle.
- R6: A capture produces exactly FRAME = LEAD_DUMMY+IMAGE_PIX+TRAIL_DUMMY strobes. `pixel_idx` runs 0,1,...,FRAME-1 in order, strobes are spaced 4*HALF_CYC cycles apart, and `icg` stays high throughout.
- R7: With INVERT=1, `mclk`, `icg` and `sh` are the bitwise complement of the INVERT=0 outputs under identical stimulus.
- R8: `integ_start` is high for exactly one cycle, and that cycle is the one in which `sh` goes low.
- R9: After a capture, `done` is high for exactly one cycle, 4*HALF_CYC cycles after the last strobe.
- R10: A clear request raises no strobes. Its `done` comes FRAME*4*HALF_CYC+CLEAR_PAD_CYC cycles after the `icg` release.
- R11: A request that arrives while a sequence is running is held. `icg` then falls in the cycle after that sequence's `done`. If start and clear arrive together, start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a capture frame |
| clear | input | 1 | Request a flush frame without strobes |
| mclk | output | 1 | Sensor master clock |
| icg | output | 1 | Integration-clear gate |
| sh | output | 1 | Shift gate |
| sample_strobe | output | 1 | One-cycle converter trigger per pixel slot |
| pixel_idx | output | IDXW | Index of the slot being sampled |
| integ_start | output | 1 | One-cycle marker of exposure start |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Captures are launched at every phase offset across two master periods. This tests whether the `icg` release and the first strobe always snap to a rising `mclk` edge, whatever the phase of the request. It also tests whether the tail wait stretches only as far as one master period allows. Clear requests at several offsets separate a flush frame from a capture by the absence of strobes and by the padded `done` time. A second request issued in the middle of a frame, with start and clear asserted together, checks that the request is held until `done` and that start takes priority. A twin instance with inverted polarity is compared pin by pin against the normal one throughout the run.

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen #(
  parameter int HALF_CYC      = 25,
  parameter int LEAD_DUMMY    = 32,
  parameter int IMAGE_PIX     = 1500,
  parameter int TRAIL_DUMMY   = 14,
  parameter int ICG_LEAD_CYC  = 20,
  parameter int SH_HIGH_CYC   = 120,
  parameter int SH_TAIL_CYC   = 120,
  parameter int CLEAR_PAD_CYC = 400,
  parameter bit INVERT        = 1'b0,
  localparam int FRAME = LEAD_DUMMY + IMAGE_PIX + TRAIL_DUMMY,
  localparam int IDXW  = $clog2(FRAME)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            clear,
  output logic            mclk,
  output logic            icg,
  output logic            sh,
  output logic            sample_strobe,
  output logic [IDXW-1:0] pixel_idx,
  output logic            integ_start,
  output logic            done
);

  localparam int HW   = $clog2(HALF_CYC + 1);
  localparam int T1   = (ICG_LEAD_CYC > SH_HIGH_CYC) ? ICG_LEAD_CYC : SH_HIGH_CYC;
  localparam int T2   = (SH_TAIL_CYC > CLEAR_PAD_CYC) ? SH_TAIL_CYC : CLEAR_PAD_CYC;
  localparam int TMAX = (T1 > T2) ? T1 : T2;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHH, S_TAIL, S_READ, S_PAD} state_t;

  state_t          state;
  logic [HW-1:0]   hc;
  logic            mclk_q, icg_q, sh_q, strobe_q, integ_q, done_q;
  logic            clr_mode, odd, pend, pend_clr;
  logic [TW-1:0]   tmr;
  logic [IDXW-1:0] idx;

  wire rise   = (hc == HW'(HALF_CYC - 1)) && !mclk_q;
  wire go     = start || clear || pend;
  wire go_clr = pend ? pend_clr : !start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc     <= '0;
      mclk_q <= 1'b0;
    end else if (hc == HW'(HALF_CYC - 1)) begin
      hc     <= '0;
      mclk_q <= !mclk_q;
    end else begin
      hc <= hc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      icg_q    <= 1'b1;
      sh_q     <= 1'b0;
      strobe_q <= 1'b0;
      integ_q  <= 1'b0;
      done_q   <= 1'b0;
      clr_mode <= 1'b0;
      odd      <= 1'b0;
      pend     <= 1'b0;
      pend_clr <= 1'b0;
      tmr      <= '0;
      idx      <= '0;
    end else begin
      strobe_q <= 1'b0;
      integ_q  <= 1'b0;
      done_q   <= 1'b0;
      if (tmr != TW'(TMAX)) tmr <= tmr + 1'b1;
      if (state != S_IDLE && (start || clear) && !pend) begin
        pend     <= 1'b1;
        pend_clr <= !start;
      end
      case (state)
        S_IDLE: if (go) begin
          state    <= S_LEAD;
          icg_q    <= 1'b0;
          tmr      <= '0;
          clr_mode <= go_clr;
          pend     <= 1'b0;
        end
        S_LEAD: if (tmr == TW'(ICG_LEAD_CYC - 1)) begin
          state <= S_SHH;
          sh_q  <= 1'b1;
          tmr   <= '0;
        end
        S_SHH: if (tmr == TW'(SH_HIGH_CYC - 1)) begin
          state   <= S_TAIL;
          sh_q    <= 1'b0;
          integ_q <= 1'b1;
          tmr     <= '0;
        end
        S_TAIL: if (tmr >= TW'(SH_TAIL_CYC - 1) && rise) begin
          state    <= S_READ;
          icg_q    <= 1'b1;
          idx      <= '0;
          odd      <= 1'b1;
          strobe_q <= !clr_mode;
        end
        S_READ: if (rise) begin
          if (odd) begin
            odd <= 1'b0;
          end else if (idx == IDXW'(FRAME - 1)) begin
            if (clr_mode) begin
              state <= S_PAD;
              tmr   <= '0;
            end else begin
              state  <= S_IDLE;
              done_q <= 1'b1;
            end
          end else begin
            idx      <= idx + 1'b1;
            odd      <= 1'b1;
            strobe_q <= !clr_mode;
          end
        end
        S_PAD: if (tmr == TW'(CLEAR_PAD_CYC - 1)) begin
          state  <= S_IDLE;
          done_q <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mclk          = mclk_q ^ INVERT;
  assign icg           = icg_q ^ INVERT;
  assign sh            = sh_q ^ INVERT;
  assign sample_strobe = strobe_q;
  assign pixel_idx     = idx;
  assign integ_start   = integ_q;
  assign done          = done_q;

endmodule

module ccd_timing_gen_chk #(
  parameter bit INVERT = 1'b0,
  parameter int FRAME  = 8,
  parameter int IDXW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mclk,
  input logic            icg,
  input logic            sh,
  input logic            sample_strobe,
  input logic [IDXW-1:0] pixel_idx,
  input logic            integ_start,
  input logic            done
);
  wire m_t = mclk ^ INVERT;
  wire i_t = icg ^ INVERT;
  wire s_t = sh ^ INVERT;

  AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> m_t && !$past(m_t)); // R2
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> !sample_strobe); // R2
  AST_SH_INSIDE_ICG: assert property (@(posedge clk) disable iff (!rst_n)
    s_t |-> !i_t); // R4
  AST_ICG_RELEASE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(i_t) |-> m_t && !$past(m_t)); // R5
  AST_IDX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> (int'(pixel_idx) < FRAME) && i_t); // R6
  AST_INTEG_AT_SH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    integ_start |-> !s_t && $past(s_t)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

bind ccd_timing_gen ccd_timing_gen_chk #(.INVERT(INVERT), .FRAME(FRAME), .IDXW(IDXW)) u_chk (.*);

// File: tb/ccd_timing_gen_tb.sv
`timescale 1ns/1ps
module ccd_timing_gen_tb;
  localparam int H = 2, LD = 2, IM = 5, TR = 1, F = LD + IM + TR;
  localparam int IL = 3, SHW = 4, ST = 3, PAD = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, clear = 1'b0;
  logic mclk, icg, sh, stb, integ, done;
  logic [2:0] idx;
  logic mclk_n, icg_n, sh_n, stb_n, integ_n, done_n;
  logic [2:0] idx_n;

  int tests = 0, fails = 0, cyc = 0;
  int t_icgf = 0, t_shr = 0, t_shf = 0, t_icgr = 0, t_last = 0, t_done = 0;
  int nstrobe = 0, ndone = 0, run = 0;
  logic pm = 1'b0, pi = 1'b1, ps = 1'b0, pd = 1'b0;
  bit in_clear = 1'b0;

  always #2 clk = ~clk;

  ccd_timing_gen #(.HALF_CYC(H), .LEAD_DUMMY(LD), .IMAGE_PIX(IM), .TRAIL_DUMMY(TR),
    .ICG_LEAD_CYC(IL), .SH_HIGH_CYC(SHW), .SH_TAIL_CYC(ST), .CLEAR_PAD_CYC(PAD),
    .INVERT(1'b0)) u_dut (.clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
    .mclk(mclk), .icg(icg), .sh(sh), .sample_strobe(stb), .pixel_idx(idx),
    .integ_start(integ), .done(done));

  ccd_timing_gen #(.HALF_CYC(H), .LEAD_DUMMY(LD), .IMAGE_PIX(IM), .TRAIL_DUMMY(TR),
    .ICG_LEAD_CYC(IL), .SH_HIGH_CYC(SHW), .SH_TAIL_CYC(ST), .CLEAR_PAD_CYC(PAD),
    .INVERT(1'b1)) u_inv (.clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
    .mclk(mclk_n), .icg(icg_n), .sh(sh_n), .sample_strobe(stb_n), .pixel_idx(idx_n),
    .integ_start(integ_n), .done(done_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cyc > 150000) begin
        chk(1'b0, "watchdog", cyc, 150000);
        summary();
      end
      chk({mclk_n, icg_n, sh_n} == ~{mclk, icg, sh}, "R7 inverted pins",
          int'({mclk_n, icg_n, sh_n}), int'(~{mclk, icg, sh}));
      if (mclk != pm) begin
        if (cyc > 8) chk(run == H, "R1 mclk phase length", run, H);
        run = 1;
      end else run++;
      if (pi && !icg) begin t_icgf = cyc; nstrobe = 0; end
      if (!ps && sh) begin t_shr = cyc; chk(cyc - t_icgf == IL, "R4 icg-low to sh-high", cyc - t_icgf, IL); end
      if (ps && !sh) begin
        t_shf = cyc;
        chk(cyc - t_shr == SHW, "R4 sh width", cyc - t_shr, SHW);
        chk(integ == 1'b1, "R8 integ_start at sh fall", int'(integ), 1);
      end else if (integ) chk(1'b0, "R8 stray integ_start", 1, 0);
      if (!pi && icg) begin
        t_icgr = cyc;
        chk(cyc - t_shf >= ST && cyc - t_shf <= ST + 2*H - 1, "R4 sh-low to icg release",
            cyc - t_shf, ST);
        chk(mclk && !pm, "R5 release on mclk rise", int'(mclk), 1);
        chk(stb == !in_clear, "R5 first strobe at release", int'(stb), int'(!in_clear));
      end
      if (stb) begin
        if (in_clear) chk(1'b0, "R10 strobe during clear", 1, 0);
        chk(int'(idx) == nstrobe, "R6 pixel index", int'(idx), nstrobe);
        if (nstrobe > 0) chk(cyc - t_last == 4*H, "R6 strobe spacing", cyc - t_last, 4*H);
        chk(mclk && !pm && icg, "R2 strobe on mclk rise", int'(mclk), 1);
        nstrobe++;
        t_last = cyc;
      end
      if (done) begin
        chk(!pd, "R9 done single cycle", int'(pd), 0);
        if (in_clear)
          chk(cyc - t_icgr == F*4*H + PAD, "R10 clear done time", cyc - t_icgr, F*4*H + PAD);
        else begin
          chk(cyc - t_last == 4*H, "R9 done after last strobe", cyc - t_last, 4*H);
          chk(nstrobe == F, "R6 strobe count", nstrobe, F);
        end
        ndone++;
        t_done = cyc;
      end
      pm = mclk; pi = icg; ps = sh; pd = done;
    end
  end

  task automatic pulse(input bit s, input bit c);
    @(negedge clk); start = s; clear = c;
    @(negedge clk); start = 1'b0; clear = 1'b0;
  endtask

  task automatic wait_done();
    int target = ndone + 1;
    while (ndone < target) @(posedge clk);
  endtask

  initial begin
    int tdone1;
    repeat (3) @(negedge clk);
    chk(icg && !sh && !stb && !done && !mclk && !integ, "R3 reset levels",
        int'({icg, sh, stb, done, mclk}), 16);
    rst_n = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(icg && !sh && nstrobe == 0, "R3 idle levels", int'({icg, sh}), 2);
    for (int off = 0; off < 4*H; off++) begin
      repeat (off) @(negedge clk);
      pulse(1'b1, 1'b0);
      wait_done();
      @(negedge clk);
      chk(icg && !sh && !done, "R3 idle after capture", int'({icg, sh, done}), 4);
    end
    in_clear = 1'b1;
    for (int off = 0; off < 3; off++) begin
      repeat (off) @(negedge clk);
      pulse(1'b0, 1'b1);
      wait_done();
      @(negedge clk);
      chk(nstrobe == 0, "R10 no strobes in clear", nstrobe, 0);
    end
    in_clear = 1'b0;
    pulse(1'b1, 1'b0);
    while (nstrobe < 3) @(posedge clk);
    pulse(1'b1, 1'b1);
    chk(icg == 1'b1, "R11 frame not disturbed", int'(icg), 1);
    wait_done();
    tdone1 = t_done;
    wait_done();
    chk(t_icgf == tdone1 + 1, "R11 held request launch", t_icgf - tdone1, 1);
    chk(nstrobe == F, "R11 start wins over clear", nstrobe, F);
    repeat (10) @(negedge clk);
    summary();
  end
endmodule